// File: doc/BRIEF.md
# Truncated Non-Contiguous Down Counter

This block is a synchronous down counter. Its eight-bit count register is split into two four-bit stages. Each stage counts down modulo sixteen. The low stage's zero flag gates the decrement of the high stage, and each stage can be overwritten in one clock by a parallel load.

Two load rules cut the natural 256-state down-count to a loop of 21 states:

- When the count reaches zero, the next value is 31.
- When the count reaches 23, the next value is 11.

The visited values are therefore 31 down to 23, then 11 down to 0, and then the loop starts again. Values from 12 to 22, and everything above 31, never appear. The zero condition comes from the two per-stage zero flags. A separate comparator detects the value 23.

A count-enable input gates every change, both counting and loading. Reset is asynchronous and active low, and it puts the counter at 31.

Top module: `truncDownCounter`

## Requirements
- R1: While rstN is low, and at once when it falls, count reads 31 (0x1F) and tcFlags reads 2'b00.
- R2: On a rising clock edge with cntEn high and count not equal to 0 or 23, count becomes its previous value minus one.
- R3: On a rising clock edge with cntEn high and count equal to 0, count becomes 31.
- R4: On a rising clock edge with cntEn high and count equal to 23, count becomes 11.
- R5: On a rising clock edge with cntEn low, count keeps its value, including when it sits at 0 or 23.
- R6: tcFlags bit 0 is high exactly when count[3:0] is zero. tcFlags bit 1 is high exactly when count[7:4] is zero.
- R7: After reset, count never takes a value in the range 12 to 22 or above 31.
- R8: With cntEn held high, count runs through a loop of exactly 21 distinct states and returns to 31 after 21 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cntEn | input | 1 | Count enable; when low, count holds |
| count | output | 8 | Current count value |
| tcFlags | output | 2 | Per-stage zero flags, bit 0 for the low nibble |

## Verification
A wrong stage value shows on count at the first sample after the edge that produced it. A faulty zero flag appears on tcFlags in that same sample. A broken wrap or jump decode shows one edge after the count reaches 0 or 23: either the next value is wrong, or a forbidden value between 12 and 22 appears. Every visible count is checked against an arithmetic model, so a wrong internal state costs at most one clock before it is seen at the ports. A wrong loop length is caught within one 21-state loop.

// File: rtl/trunc_cnt_pkg.sv
package trunc_cnt_pkg;
  localparam int NIB_W  = 4;
  localparam int STAGES = 2;
  localparam int CNT_W  = NIB_W * STAGES;

  typedef struct packed {
    logic step;      // ordinary decrement through the borrow chain
    logic loadWrap;  // zero reached: load wrap value
    logic loadJump;  // jump source reached: load jump target
  } cntStrobes_t;
endpackage

// File: rtl/trunc_cnt_datapath.sv
module trunc_cnt_datapath
  import trunc_cnt_pkg::*;
#(
  parameter logic [CNT_W-1:0] RESET_V = 8'd31,
  parameter logic [CNT_W-1:0] WRAP_V  = 8'd31,
  parameter logic [CNT_W-1:0] JUMP_V  = 8'd11
) (
  input  logic              clk,
  input  logic              rstN,
  input  cntStrobes_t       strobes,
  output logic [CNT_W-1:0]  count,
  output logic [STAGES-1:0] tcFlags
);
  logic [STAGES:0] borrow;

  assign borrow[0] = strobes.step;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [NIB_W-1:0] nib;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        nib <= RESET_V[s*NIB_W +: NIB_W];
      end else if (strobes.loadWrap) begin
        nib <= WRAP_V[s*NIB_W +: NIB_W];
      end else if (strobes.loadJump) begin
        nib <= JUMP_V[s*NIB_W +: NIB_W];
      end else if (borrow[s]) begin
        nib <= nib - 1'b1;
      end
    end

    assign tcFlags[s]              = (nib == '0);
    assign borrow[s+1]             = borrow[s] & tcFlags[s];
    assign count[s*NIB_W +: NIB_W] = nib;
  end
endmodule

// File: rtl/trunc_cnt_control.sv
module trunc_cnt_control
  import trunc_cnt_pkg::*;
#(
  parameter logic [CNT_W-1:0] JUMP_FROM = 8'd23
) (
  input  logic              cntEn,
  input  logic [CNT_W-1:0]  count,
  input  logic [STAGES-1:0] tcFlags,
  output cntStrobes_t       strobes
);
  logic atZero;
  logic atJump;

  assign atZero = &tcFlags;
  assign atJump = (count == JUMP_FROM);

  always_comb begin
    strobes.loadWrap = cntEn & atZero;
    strobes.loadJump = cntEn & ~atZero & atJump;
    strobes.step     = cntEn & ~atZero & ~atJump;
  end
endmodule

// File: rtl/truncDownCounter.sv
module truncDownCounter
  import trunc_cnt_pkg::*;
#(
  parameter int RESET_VAL = 31,
  parameter int WRAP_VAL  = 31,
  parameter int JUMP_SRC  = 23,
  parameter int JUMP_DST  = 11
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cntEn,
  output logic [trunc_cnt_pkg::CNT_W-1:0]  count,
  output logic [trunc_cnt_pkg::STAGES-1:0] tcFlags
);
  localparam logic [CNT_W-1:0] RESET_V = CNT_W'(RESET_VAL);
  localparam logic [CNT_W-1:0] WRAP_V  = CNT_W'(WRAP_VAL);
  localparam logic [CNT_W-1:0] SRC_V   = CNT_W'(JUMP_SRC);
  localparam logic [CNT_W-1:0] DST_V   = CNT_W'(JUMP_DST);

  cntStrobes_t strobes;

  trunc_cnt_control #(.JUMP_FROM(SRC_V)) u_ctrl (
    .cntEn  (cntEn),
    .count  (count),
    .tcFlags(tcFlags),
    .strobes(strobes)
  );

  trunc_cnt_datapath #(.RESET_V(RESET_V), .WRAP_V(WRAP_V), .JUMP_V(DST_V)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .count  (count),
    .tcFlags(tcFlags)
  );
endmodule

// File: rtl/truncDownCounter_chk.sv
module truncDownCounter_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cntEn,
  input logic [7:0] count,
  input logic [1:0] tcFlags
);
  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && count != 8'd0 && count != 8'd23) |=> (count == $past(count) - 8'd1));

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && count == 8'd0) |=> (count == 8'd31));

  a_r4_jump: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && count == 8'd23) |=> (count == 8'd11));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cntEn |=> $stable(count));

  a_r6_tc_flags: assert property (@(posedge clk) disable iff (!rstN)
    (tcFlags[0] == (count[3:0] == 4'd0)) && (tcFlags[1] == (count[7:4] == 4'd0)));

  a_r7_legal_range: assert property (@(posedge clk) disable iff (!rstN)
    (count <= 8'd31) && !(count >= 8'd12 && count <= 8'd22));
endmodule

bind truncDownCounter truncDownCounter_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .cntEn  (cntEn),
  .count  (count),
  .tcFlags(tcFlags)
);

// File: tb/test_truncDownCounter.sv
`timescale 1ns/1ps
module test_truncDownCounter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cntEn = 1'b0;
  logic [7:0] count;
  logic [1:0] tcFlags;

  int total = 0;
  int bad = 0;
  int expCnt = 31;
  logic done = 1'b0;

  always #2 clk = ~clk;

  truncDownCounter i_truncDownCounter (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .count(count), .tcFlags(tcFlags)
  );

  function automatic int nextOf(int v);
    if (v == 0) return 31;
    if (v == 23) return 11;
    return v - 1;
  endfunction

  function automatic string tagOf(int v);
    if (v == 0) return "R3";
    if (v == 23) return "R4";
    return "R2";
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkState(string req);
    check(req, int'(count), expCnt);
    check("R6", int'(tcFlags), {30'd0, (expCnt[7:4] == 4'd0), (expCnt[3:0] == 4'd0)});
    check("R7", int'((count <= 31) && !(count >= 12 && count <= 22)), 1);
  endtask

  // drive at a falling edge, check at the following falling edge
  task automatic stepCycle(logic en);
    string req;
    cntEn = en;
    req = en ? tagOf(expCnt) : "R5";
    @(negedge clk);
    expCnt = en ? nextOf(expCnt) : expCnt;
    checkState(req);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int loopLen;
    // R1 reset value
    @(negedge clk);
    checkState("R1");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkState("R1");

    // R2, R3, R4: three full loops with cntEn held high
    for (int i = 0; i < 63; i++) stepCycle(1'b1);

    // R8: loop length from 31 back to 31
    while (expCnt != 31) stepCycle(1'b1);
    loopLen = 0;
    do begin
      stepCycle(1'b1);
      loopLen++;
    end while (expCnt != 31 && loopLen < 40);
    check("R8", loopLen, 21);

    // R5 hold at 23 then jump (R4)
    while (expCnt != 23) stepCycle(1'b1);
    for (int i = 0; i < 3; i++) stepCycle(1'b0);
    stepCycle(1'b1);
    check("R4", int'(count), 11);

    // R5 hold at 0 then wrap (R3)
    while (expCnt != 0) stepCycle(1'b1);
    for (int i = 0; i < 3; i++) stepCycle(1'b0);
    stepCycle(1'b1);
    check("R3", int'(count), 31);

    // mixed enable pattern over several loops
    for (int i = 0; i < 150; i++) stepCycle((i % 3) != 1);

    // R1 asynchronous reset mid-count, sampled between edges
    while (expCnt != 5) stepCycle(1'b1);
    #1 rstN = 1'b0;
    #0.5;
    expCnt = 31;
    checkState("R1");
    @(negedge clk);
    rstN = 1'b1;
    checkState("R1");
    for (int i = 0; i < 25; i++) stepCycle(1'b1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule